// File: doc/BRIEF.md
# Privileged-Mode Trap Sequencer

This block owns the program counter of a small core and sequences every entry into and exit from its privileged mode. A fault or trap request, tagged with a kind code, redirects the PC to a handler at a programmable base address plus a per-kind offset. It also records a restart address and, when the core was running in normal mode, exchanges a fixed group of integer registers with a private shadow copy. A return request sends the PC back to the recorded address and restores the normal copies when the recorded address says normal mode. Privileged mode is bit 0 of the current PC. A handler address with bit 0 set therefore runs privileged, and a saved address with bit 0 set returns to privileged code.

The integer register file sits inside the block. It has one write port and one combinational read port. Eight of its entries are banked: indices 8 to 14 and index 25. Each banked entry has a shadow twin, and a bank switch exchanges all eight pairs in one clock edge. Arithmetic traps are not handled. A request of that kind only raises an error pulse.

Top module: `priv_trap_ctl`

## Requirements
- R1: After reset the PC is BASE_RST + 0x001 (0x4001 by default), so the core starts privileged. The shadow bank is active, the saved address is 0 and every register reads 0.
- R2: On entry the PC becomes base + offset for the kind on req_kind_i. The codes and offsets are: 0 machine check 0x401, 1 alignment 0x301, 2 interrupt 0x101, 3 privileged call 0x2001. An illegal return (R6) uses offset 0x081.
- R3: A fault kind (0, 1, 2, illegal return) saves the PC of the faulting instruction. A privileged call (3) saves PC+4.
- R4: An interrupt taken while already privileged leaves the saved address unchanged.
- R5: An entry from normal mode activates the shadow bank, exchanging registers 8 to 14 and 25 with their twins in one edge. An entry from privileged mode performs no exchange.
- R6: A return request in normal mode does not return. It enters the handler as an illegal-opcode fault and saves the current PC.
- R7: A return request in privileged mode loads the PC from the saved address. It deactivates the shadow bank only if bit 0 of that address is 0. It pulses intr_arm_o for the cycle after the edge.
- R8: A bank switch towards the state already active performs no exchange and pulses swap_err_o.
- R9: An arithmetic-trap request (kind 4) pulses arith_err_o and leaves the PC, the saved address and the bank unchanged.
- R10: npc_o is always pc_o + 4. step_i advances the PC by 4 when no request is taken.
- R11: A write of the base register changes the handler address of every later entry and nothing else.
- R12: Registers outside the banked set are never exchanged. A value written to one stays visible across every switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Fault or trap request |
| req_kind_i | input | 3 | Request kind code (R2, R9) |
| rei_valid_i | input | 1 | Return-from-exception request |
| step_i | input | 1 | Advance PC by 4 |
| base_wr_i | input | 1 | Base register write enable |
| base_data_i | input | 32 | Base register write data |
| rf_wr_i | input | 1 | Register write enable |
| rf_wr_idx_i | input | 5 | Register write index |
| rf_wr_data_i | input | 32 | Register write data |
| rf_rd_idx_i | input | 5 | Register read index |
| rf_rd_data_o | output | 32 | Register read data (combinational) |
| pc_o | output | 32 | Current PC |
| npc_o | output | 32 | Next sequential PC |
| exc_addr_o | output | 32 | Saved restart address |
| shadow_o | output | 1 | Shadow bank active |
| priv_o | output | 1 | Privileged mode (PC bit 0) |
| intr_arm_o | output | 1 | Interrupt check re-armed |
| arith_err_o | output | 1 | Arithmetic trap rejected |
| swap_err_o | output | 1 | Redundant bank switch |

## Verification
Every PC, saved address, bank state and pulse output is registered. Each of them is due exactly one rising edge after the cycle in which its request was driven. The driver applies a request at a falling edge and withdraws it just after the next rising edge. It then queues the expected values, and the monitor compares them at the following falling edge. Register contents come through the combinational read port. They are checked a fraction of a cycle after the index is set, in idle cycles, so no exchange can be in flight.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;

  typedef enum logic [2:0] {
    TK_MCHK  = 3'd0,
    TK_ALIGN = 3'd1,
    TK_INTR  = 3'd2,
    TK_CALL  = 3'd3,
    TK_ARITH = 3'd4,
    TK_ILLOP = 3'd5
  } trap_kind_e;

  localparam int NBANK = 8;

  // banked integer registers: 8..14 and 25
  function automatic bit is_banked(int idx);
    return ((idx >= 8) && (idx <= 14)) || (idx == 25);
  endfunction

  function automatic int bank_slot(int idx);
    return (idx == 25) ? 7 : (idx - 8);
  endfunction

  function automatic int bank_reg(int slot);
    return (slot == 7) ? 25 : (slot + 8);
  endfunction

endpackage

// File: rtl/ptc_vec_sel.sv
`timescale 1ns/1ps
module ptc_vec_sel
  import ptc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFS_MCHK  = 'h401,
  parameter int OFS_ALIGN = 'h301,
  parameter int OFS_INTR  = 'h101,
  parameter int OFS_CALL  = 'h2001,
  parameter int OFS_ILLOP = 'h081
) (
  input  trap_kind_e          kind,
  output logic [ADDR_W-1:0]   ofs,
  output logic                skip_insn
);

  always_comb begin
    skip_insn = 1'b0;
    case (kind)
      TK_MCHK:  ofs = ADDR_W'(OFS_MCHK);
      TK_ALIGN: ofs = ADDR_W'(OFS_ALIGN);
      TK_INTR:  ofs = ADDR_W'(OFS_INTR);
      TK_CALL: begin
        ofs       = ADDR_W'(OFS_CALL);
        skip_insn = 1'b1;
      end
      default:  ofs = ADDR_W'(OFS_ILLOP);
    endcase
  end

endmodule

// File: rtl/ptc_seq.sv
`timescale 1ns/1ps
module ptc_seq
  import ptc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_RST  = 'h4000,
  parameter int RESET_OFS = 'h001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              rei_valid,
  input  logic              step,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_data,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] exc_q,
  output logic              swap_req,
  output logic              swap_to,
  output logic              arm_q,
  output logic              aerr_q
);

  localparam logic [ADDR_W-1:0] PC_RST   = ADDR_W'(BASE_RST + RESET_OFS);
  localparam logic [ADDR_W-1:0] BASE_INI = ADDR_W'(BASE_RST);
  localparam logic [ADDR_W-1:0] INSN_B   = ADDR_W'(4);

  trap_kind_e        kind, eff_kind;
  logic [ADDR_W-1:0] base_q, ofs;
  logic              skip_insn, priv;
  logic              is_arith, take_req, take_ill, do_ret, enter;
  logic [ADDR_W-1:0] pc_d, exc_d;
  logic              pc_en, exc_en, arm_d, aerr_d;

  assign kind     = trap_kind_e'(req_kind);
  assign priv     = pc_q[0];
  assign is_arith = req_valid && (kind == TK_ARITH);
  assign take_req = req_valid && !is_arith;
  assign take_ill = rei_valid && !req_valid && !priv;
  assign do_ret   = rei_valid && !req_valid && priv;
  assign enter    = take_req || take_ill;
  assign eff_kind = take_req ? kind : TK_ILLOP;

  ptc_vec_sel #(.ADDR_W(ADDR_W)) u_vec (
    .kind      (eff_kind),
    .ofs       (ofs),
    .skip_insn (skip_insn)
  );

  always_comb begin
    pc_d     = pc_q;
    pc_en    = 1'b0;
    exc_d    = exc_q;
    exc_en   = 1'b0;
    swap_req = 1'b0;
    swap_to  = 1'b0;
    arm_d    = 1'b0;
    aerr_d   = is_arith;
    if (enter) begin
      pc_d  = base_q + ofs;
      pc_en = 1'b1;
      if (!((eff_kind == TK_INTR) && priv)) begin
        exc_d  = skip_insn ? (pc_q + INSN_B) : pc_q;
        exc_en = 1'b1;
      end
      if (!priv) begin
        swap_req = 1'b1;
        swap_to  = 1'b1;
      end
    end else if (do_ret) begin
      pc_d  = exc_q;
      pc_en = 1'b1;
      arm_d = 1'b1;
      if (!exc_q[0]) begin
        swap_req = 1'b1;
        swap_to  = 1'b0;
      end
    end else if (step && !is_arith) begin
      pc_d  = pc_q + INSN_B;
      pc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= PC_RST;
      exc_q  <= '0;
      base_q <= BASE_INI;
      arm_q  <= 1'b0;
      aerr_q <= 1'b0;
    end else begin
      if (pc_en)   pc_q   <= pc_d;
      if (exc_en)  exc_q  <= exc_d;
      if (base_wr) base_q <= base_data;
      arm_q  <= arm_d;
      aerr_q <= aerr_d;
    end
  end

  AST_ARITH_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd4) |=> $stable(pc_q) && $stable(exc_q)); // R9

  AST_PRIV_INTR_KEEPS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd2 && pc_q[0]) |=> $stable(exc_q)); // R4

  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (rei_valid && !req_valid && pc_q[0]) |=> (pc_q == $past(exc_q))); // R7

  AST_ARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> $past(rei_valid && !req_valid && pc_q[0])); // R7

endmodule

// File: rtl/ptc_shadow_rf.sv
`timescale 1ns/1ps
module ptc_shadow_rf
  import ptc_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    swap_req,
  input  logic                    swap_to,
  output logic                    sh_q,
  output logic                    swap_err_q
);

  localparam int IDX_W = $clog2(NREG);

  logic [NREG-1:0][DATA_W-1:0]  main_v;
  logic [NBANK-1:0][DATA_W-1:0] shad_v;
  logic                         swap_do;

  assign swap_do = swap_req && (swap_to != sh_q);
  assign rd_data = main_v[rd_idx];

  for (genvar i = 0; i < NREG; i++) begin : g_main
    localparam bit BK = is_banked(i);
    localparam int SL = BK ? bank_slot(i) : 0;
    logic [DATA_W-1:0] r_q, r_d;
    logic              r_en;
    if (BK) begin : g_bk
      always_comb begin
        r_en = swap_do || (wr_en && (wr_idx == IDX_W'(i)));
        r_d  = swap_do ? shad_v[SL] : wr_data;
      end
    end else begin : g_plain
      always_comb begin
        r_en = wr_en && (wr_idx == IDX_W'(i));
        r_d  = wr_data;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r_q <= '0;
      else if (r_en) r_q <= r_d;
    end
    assign main_v[i] = r_q;
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_shad
    localparam int RI = bank_reg(k);
    logic [DATA_W-1:0] s_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       s_q <= '0;
      else if (swap_do) s_q <= main_v[RI];
    end
    assign shad_v[k] = s_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= 1'b1;
      swap_err_q <= 1'b0;
    end else begin
      if (swap_do) sh_q <= swap_to;
      swap_err_q <= swap_req && !swap_do;
    end
  end

  AST_SWAP_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && (swap_to != sh_q)) |=> (sh_q == $past(swap_to))); // R5

  AST_REDUNDANT_SWAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && (swap_to == sh_q)) |=> $stable(sh_q)); // R8

  AST_SWAP_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    swap_err_q |-> $past(swap_req)); // R8

endmodule

// File: rtl/priv_trap_ctl.sv
`timescale 1ns/1ps
module priv_trap_ctl #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NREG     = 32,
  parameter int BASE_RST = 'h4000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid_i,
  input  logic [2:0]              req_kind_i,
  input  logic                    rei_valid_i,
  input  logic                    step_i,
  input  logic                    base_wr_i,
  input  logic [ADDR_W-1:0]       base_data_i,
  input  logic                    rf_wr_i,
  input  logic [$clog2(NREG)-1:0] rf_wr_idx_i,
  input  logic [DATA_W-1:0]       rf_wr_data_i,
  input  logic [$clog2(NREG)-1:0] rf_rd_idx_i,
  output logic [DATA_W-1:0]       rf_rd_data_o,
  output logic [ADDR_W-1:0]       pc_o,
  output logic [ADDR_W-1:0]       npc_o,
  output logic [ADDR_W-1:0]       exc_addr_o,
  output logic                    shadow_o,
  output logic                    priv_o,
  output logic                    intr_arm_o,
  output logic                    arith_err_o,
  output logic                    swap_err_o
);

  logic swap_req, swap_to;

  ptc_seq #(.ADDR_W(ADDR_W), .BASE_RST(BASE_RST)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid_i),
    .req_kind  (req_kind_i),
    .rei_valid (rei_valid_i),
    .step      (step_i),
    .base_wr   (base_wr_i),
    .base_data (base_data_i),
    .pc_q      (pc_o),
    .exc_q     (exc_addr_o),
    .swap_req  (swap_req),
    .swap_to   (swap_to),
    .arm_q     (intr_arm_o),
    .aerr_q    (arith_err_o)
  );

  ptc_shadow_rf #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (rf_wr_i),
    .wr_idx     (rf_wr_idx_i),
    .wr_data    (rf_wr_data_i),
    .rd_idx     (rf_rd_idx_i),
    .rd_data    (rf_rd_data_o),
    .swap_req   (swap_req),
    .swap_to    (swap_to),
    .sh_q       (shadow_o),
    .swap_err_q (swap_err_o)
  );

  assign npc_o  = pc_o + ADDR_W'(4);
  assign priv_o = pc_o[0];

  AST_PRIV_ENTRY_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_kind_i != 3'd4 && pc_o[0]) |=> $stable(shadow_o)); // R5

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !req_valid_i && !rei_valid_i) |=> (pc_o == $past(npc_o))); // R10

endmodule

// File: tb/priv_trap_ctl_test.sv
`timescale 1ns/1ps
module priv_trap_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic        rei_valid = 1'b0;
  logic        step = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_data = '0;
  logic        rf_wr = 1'b0;
  logic [4:0]  rf_wr_idx = '0;
  logic [31:0] rf_wr_data = '0;
  logic [4:0]  rf_rd_idx = '0;
  logic [31:0] rf_rd_data, pc, npc, exc;
  logic        shadow, priv, arm, aerr, serr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  priv_trap_ctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .rei_valid_i(rei_valid), .step_i(step), .base_wr_i(base_wr),
    .base_data_i(base_data), .rf_wr_i(rf_wr), .rf_wr_idx_i(rf_wr_idx),
    .rf_wr_data_i(rf_wr_data), .rf_rd_idx_i(rf_rd_idx), .rf_rd_data_o(rf_rd_data),
    .pc_o(pc), .npc_o(npc), .exc_addr_o(exc), .shadow_o(shadow), .priv_o(priv),
    .intr_arm_o(arm), .arith_err_o(aerr), .swap_err_o(serr)
  );

  typedef struct {
    logic [31:0] pc;
    logic [31:0] exc;
    logic        sh;
    logic        arm;
    logic        aerr;
    logic        serr;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // reference model state, from the requirements
  logic [31:0] m_pc, m_exc, m_base;
  logic        m_sh;

  function automatic logic [31:0] ofs_of(int k);
    case (k)
      0: return 32'h401;
      1: return 32'h301;
      2: return 32'h101;
      3: return 32'h2001;
      default: return 32'h081;
    endcase
  endfunction

  task automatic model_reset();
    m_pc = 32'h4001; m_exc = 0; m_sh = 1'b1; m_base = 32'h4000;
  endtask

  task automatic model_enter(int k, output logic se);
    logic p;
    p  = m_pc[0];
    se = 1'b0;
    if (!(k == 2 && p)) m_exc = (k == 3) ? m_pc + 4 : m_pc;
    if (!p) begin
      se = m_sh;
      m_sh = 1'b1;
    end
    m_pc = m_base + ofs_of(k);
  endtask

  task automatic op(input logic rv, input int k, input logic rei, input logic st,
                    input logic bw, input logic [31:0] bd, input string tag);
    exp_t e;
    e.arm = 0; e.aerr = 0; e.serr = 0; e.tag = tag;
    @(negedge clk);
    req_valid = rv; req_kind = 3'(k); rei_valid = rei; step = st;
    base_wr = bw; base_data = bd;
    if (rv && k == 4) e.aerr = 1;
    else if (rv) model_enter(k, e.serr);
    else if (rei && !m_pc[0]) model_enter(5, e.serr);
    else if (rei) begin
      m_pc = m_exc;
      e.arm = 1;
      if (!m_exc[0]) begin
        e.serr = !m_sh;
        m_sh = 1'b0;
      end
    end else if (st) m_pc = m_pc + 4;
    if (bw) m_base = bd;
    e.pc = m_pc; e.exc = m_exc; e.sh = m_sh;
    @(posedge clk);
    #1;
    req_valid = 0; rei_valid = 0; step = 0; base_wr = 0;
    sb.push_back(e);
  endtask

  task automatic idle(string tag);       op(0, 0, 0, 0, 0, 0, tag); endtask
  task automatic fault(int k, string tag); op(1, k, 0, 0, 0, 0, tag); endtask
  task automatic ret(string tag);        op(0, 0, 1, 0, 0, 0, tag); endtask
  task automatic stp(string tag);        op(0, 0, 0, 1, 0, 0, tag); endtask

  task automatic wr_reg(input int idx, input logic [31:0] val);
    @(negedge clk);
    rf_wr = 1; rf_wr_idx = 5'(idx); rf_wr_data = val;
    @(posedge clk);
    #1;
    rf_wr = 0;
  endtask

  task automatic chk_reg(input int idx, input logic [31:0] expv, input string tag);
    @(negedge clk);
    rf_rd_idx = 5'(idx);
    #1;
    checks++;
    if (rf_rd_data !== expv) begin
      errors++;
      $display("FAIL %s: reg %0d actual %h expected %h", tag, idx, rf_rd_data, expv);
    end
  endtask

  // monitor: pops one expected item per produced result
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (pc !== e.pc || npc !== e.pc + 32'd4 || exc !== e.exc || shadow !== e.sh ||
            priv !== e.pc[0] || arm !== e.arm || aerr !== e.aerr || serr !== e.serr) begin
          errors++;
          $display("FAIL %s: actual pc=%h npc=%h exc=%h sh=%b arm=%b aerr=%b serr=%b expected pc=%h npc=%h exc=%h sh=%b arm=%b aerr=%b serr=%b",
                   e.tag, pc, npc, exc, shadow, arm, aerr, serr,
                   e.pc, e.pc + 32'd4, e.exc, e.sh, e.arm, e.aerr, e.serr);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    #2;
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1 reset state");
    chk_reg(8, 0, "R1 reset register");
    // privileged copies, shadow active
    wr_reg(8, 32'hA8); wr_reg(25, 32'hB9); wr_reg(3, 32'h33);
    ret("R7 return to even address swaps out and arms");
    chk_reg(8, 0, "R5 normal copy of r8");
    chk_reg(25, 0, "R5 normal copy of r25");
    chk_reg(3, 32'h33, "R12 unbanked r3 kept");
    wr_reg(8, 32'h18); wr_reg(25, 32'h29);
    stp("R10 step 1");
    stp("R10 step 2");
    fault(1, "R2 R3 alignment entry from normal");
    chk_reg(8, 32'hA8, "R5 shadow r8 after entry");
    chk_reg(25, 32'hB9, "R5 shadow r25 after entry");
    chk_reg(3, 32'h33, "R12 unbanked r3 after entry");
    fault(2, "R4 interrupt while privileged");
    fault(0, "R5 machine check while privileged no swap");
    chk_reg(8, 32'hA8, "R5 no exchange on privileged entry");
    ret("R7 return to odd address keeps bank");
    fault(4, "R9 arithmetic request rejected");
    do_reset();
    idle("R1 state after second reset");
    ret("R7 return after reset");
    wr_reg(8, 32'h55);
    stp("R10 step before call");
    fault(3, "R3 call saves pc+4");
    chk_reg(8, 0, "R5 shadow r8 after call");
    wr_reg(8, 32'h66);
    ret("R7 return from call");
    chk_reg(8, 32'h55, "R5 normal r8 restored");
    ret("R6 return in normal mode is illegal");
    chk_reg(8, 32'h66, "R6 illegal entry swaps in");
    ret("R7 return from illegal");
    op(0, 0, 0, 0, 1, 32'h1001, "R11 base write alone changes nothing");
    fault(0, "R11 machine check uses new base");
    chk_reg(8, 32'h66, "R11 shadow in after entry");
    fault(1, "R8 redundant swap flagged");
    chk_reg(8, 32'h66, "R8 no second exchange");
    idle("R8 error pulse clears");
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule